// File: doc/BRIEF.md
# Multi-Bank Endpoint Buffer Tracker

This block keeps the bookkeeping for the packet buffers of one bulk, interrupt or control endpoint on a USB device. It does not hold packet data. It follows which of up to three banks hold data, which bank firmware is working on, and how many bytes sit in that bank. It also keeps the handshake flags that firmware polls: ready, complete, short packet and overflow. Firmware actions arrive as one-cycle pulses: write a byte, read a byte, commit a bank for transmission, release a received bank, and kill a queued bank. The protocol engine reports three bus events as pulses: an OUT packet stored together with its length, an IN packet acknowledged by the host, and an IN token that arrives while a kill is in progress.

Two configuration inputs set the behaviour. One sets the direction (IN or OUT). The other sets the number of banks (1 to 3) and the endpoint size (8 to 1024 bytes). Change the configuration only while the tracker is cleared. Every result is registered and packed into a single status word. A combinational flag tells the protocol engine to answer NAK when an OUT packet finds no free bank.

Top module: `ep_bank_tracker`

## Requirements
- R1: After the asynchronous active-low bus reset, every status field reads zero. The status word packs byteCount in [10:0], busy-bank count in [12:11], current bank in [14:13], txRdy in [15], rxRdy in [16], txComplete in [17], short-packet in [18] and overflow in [19]. A bank-count setting of 0 acts as 1.
- R2: In IN mode, a set-TX-ready pulse raises the busy count by one when the busy count is below the bank count at the start of the cycle. When every bank is busy, the pulse has no effect.
- R3: The current bank (encodings 0, 1, 2) advances by one and wraps modulo the bank count. It advances on every accepted set-TX-ready pulse (IN) and on every accepted clear-RX-ready pulse (OUT).
- R4: In IN mode, each write pulse increments byteCount, which saturates at 2047. An accepted set-TX-ready pulse reloads byteCount with 0, because the next bank is empty.
- R5: txRdy reads 1 only in IN mode with every bank busy. rxRdy reads 1 only in OUT mode with at least one bank busy.
- R6: In IN mode, an acknowledge with at least one bank busy lowers the busy count by one and sets txComplete. txComplete stays set until a bus reset or an endpoint reset.
- R7: A kill pulse in IN mode with no IN token frees the most recently filled bank: the busy count drops by one and the current bank steps back by one, modulo the bank count. With an IN token and exactly one busy bank, the kill is refused and the bank is sent instead: the count drops by one and txComplete is set. With an IN token and two or more busy banks, one bank is sent and the last bank is killed, so the count drops by two. With no busy bank, a kill does nothing.
- R8: In OUT mode, a stored packet takes the next free bank. If no bank was busy, byteCount loads the length at once, capped at the endpoint size. Short-packet is set when the length is below the size, and overflow is set when the length is above it. Both flags update together with byteCount.
- R9: In OUT mode, an accepted clear-RX-ready pulse lowers the busy count by one. It reloads byteCount and both flags from the next bank if that bank holds a packet, including a packet stored in the same cycle. Otherwise it loads zero.
- R10: In OUT mode, each read pulse decrements byteCount, which holds at 0.
- R11: In OUT mode, a packet that arrives while every bank is busy is not stored, and outNak is 1 during that cycle.
- R12: In IN mode, OUT-side pulses (OUT stored, read, clear-RX-ready) leave the status unchanged. In OUT mode, IN-side pulses (write, set-TX-ready, acknowledge, kill) leave the status unchanged.
- R13: A synchronous endpoint-reset pulse clears every status field on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low bus reset |
| epReset | input | 1 | Synchronous endpoint reset/disable pulse |
| cfgDirIn | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfgBanks | input | 2 | Number of banks, 1 to 3 |
| cfgSize | input | 11 | Endpoint size in bytes |
| fwWrite | input | 1 | Firmware wrote one byte |
| fwRead | input | 1 | Firmware read one byte |
| fwSetTxRdy | input | 1 | Firmware commits the current bank for IN |
| fwClrRxRdy | input | 1 | Firmware releases the current OUT bank |
| fwKill | input | 1 | Firmware kills the last queued IN bank |
| busOutStored | input | 1 | OUT packet stored by the protocol engine |
| busOutLen | input | 11 | Length of the stored OUT packet |
| busInAck | input | 1 | Host acknowledged an IN packet |
| busInToken | input | 1 | IN token arriving together with a kill |
| statusWord | output | 20 | Packed status fields (see R1) |
| outNak | output | 1 | OUT packet refused, answer NAK |

## Verification
Every direction, every bank count from 1 to 3 and two endpoint sizes are run in turn. IN runs fill the banks past full and then drain them through acknowledges and through kills with and without an IN token. These runs separate the count step, the pointer step-back and the refused-kill path. OUT runs store lengths below, equal to and above the size and then overrun the banks. They release banks with and without a store in the same cycle, which tells the stored-bank reload apart from the forwarded one and from the zero reload. Events from the opposite direction are interleaved to show that they leave the status alone.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic inFill;      // IN bank committed by firmware
    logic inSent;      // IN bank taken by the host
    logic outStore;    // OUT packet written into the bus bank
    logic outLoadNow;  // store lands in the bank firmware is on
    logic outClr;      // firmware released the current OUT bank
    logic reloadNew;   // next bank is the one stored this cycle
    logic reloadOld;   // next bank already holds a packet
    logic byteInc;     // firmware write counted
    logic byteDec;     // firmware read counted
  } epStrobe_t;

endpackage

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              epReset,
  input  logic              cfgDirIn,
  input  logic [BANK_W-1:0] effBanks,
  input  logic              fwWrite,
  input  logic              fwRead,
  input  logic              fwSetTxRdy,
  input  logic              fwClrRxRdy,
  input  logic              fwKill,
  input  logic              busOutStored,
  input  logic              busInAck,
  input  logic              busInToken,
  output epStrobe_t         strobe,
  output logic [BANK_W-1:0] busyCnt,
  output logic [BANK_W-1:0] curBank,
  output logic [BANK_W-1:0] busBank,
  output logic [BANK_W-1:0] nextBank,
  output logic              outNak
);

  localparam int SUM_W = BANK_W + 1;

  logic spaceFree;
  logic inKill;
  logic [SUM_W-1:0]  busyNx;
  logic [BANK_W-1:0] curNx;
  logic [BANK_W-1:0] busNx;
  logic [BANK_W-1:0] prevBank;
  logic [BANK_W-1:0] busInc;

  function automatic logic [BANK_W-1:0] wrapInc(input logic [BANK_W-1:0] b,
                                                input logic [BANK_W-1:0] n);
    return ({1'b0, b} + 1'b1 >= {1'b0, n}) ? '0 : b + 1'b1;
  endfunction

  function automatic logic [BANK_W-1:0] wrapDec(input logic [BANK_W-1:0] b,
                                                input logic [BANK_W-1:0] n);
    return (b == '0) ? n - 1'b1 : b - 1'b1;
  endfunction

  always_comb begin
    spaceFree = busyCnt < effBanks;
    nextBank  = wrapInc(curBank, effBanks);
    prevBank  = wrapDec(curBank, effBanks);
    busInc    = wrapInc(busBank, effBanks);

    strobe.inFill  = cfgDirIn && fwSetTxRdy && spaceFree;
    strobe.inSent  = cfgDirIn && (busyCnt != '0) && (busInAck || (fwKill && busInToken));
    inKill         = cfgDirIn && fwKill && !fwSetTxRdy &&
                     (strobe.inSent ? (busyCnt >= BANK_W'(2)) : (busyCnt != '0));

    strobe.outStore   = !cfgDirIn && busOutStored && spaceFree;
    outNak            = !cfgDirIn && busOutStored && !spaceFree;
    strobe.outClr     = !cfgDirIn && fwClrRxRdy && (busyCnt != '0);
    strobe.outLoadNow = strobe.outStore && (busyCnt == '0);
    strobe.reloadOld  = strobe.outClr && (busyCnt > BANK_W'(1));
    strobe.reloadNew  = strobe.outClr && (busyCnt == BANK_W'(1)) && strobe.outStore;

    strobe.byteInc = cfgDirIn && fwWrite && !strobe.inFill;
    strobe.byteDec = !cfgDirIn && fwRead && !strobe.outClr && !strobe.outLoadNow;

    busyNx = {1'b0, busyCnt} + SUM_W'(strobe.inFill) + SUM_W'(strobe.outStore)
           - SUM_W'(strobe.inSent) - SUM_W'(inKill) - SUM_W'(strobe.outClr);

    if (strobe.inFill || strobe.outClr) curNx = nextBank;
    else if (inKill)                    curNx = prevBank;
    else                                curNx = curBank;

    busNx = (strobe.inSent || strobe.outStore) ? busInc : busBank;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      curBank <= '0;
      busBank <= '0;
    end else if (epReset) begin
      busyCnt <= '0;
      curBank <= '0;
      busBank <= '0;
    end else begin
      busyCnt <= busyNx[BANK_W-1:0];
      curBank <= curNx;
      busBank <= busNx;
    end
  end

endmodule

// File: rtl/ep_bank_data.sv
module ep_bank_data
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int LEN_W     = 11,
  parameter int BANK_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              epReset,
  input  epStrobe_t         strobe,
  input  logic [LEN_W-1:0]  cfgSize,
  input  logic [LEN_W-1:0]  busOutLen,
  input  logic [BANK_W-1:0] busBank,
  input  logic [BANK_W-1:0] nextBank,
  output logic [LEN_W-1:0]  byteCount,
  output logic              shortPkt,
  output logic              overflow,
  output logic              txComplete
);

  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] bankLen   [NUM_BANKS];
  logic             bankShort [NUM_BANKS];
  logic             bankOvf   [NUM_BANKS];

  logic [LEN_W-1:0] lenCapped;
  logic             newShort;
  logic             newOvf;

  always_comb begin
    newShort  = busOutLen < cfgSize;
    newOvf    = busOutLen > cfgSize;
    lenCapped = newOvf ? cfgSize : busOutLen;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankLen[i]   <= '0;
        bankShort[i] <= 1'b0;
        bankOvf[i]   <= 1'b0;
      end else if (epReset) begin
        bankLen[i]   <= '0;
        bankShort[i] <= 1'b0;
        bankOvf[i]   <= 1'b0;
      end else if (strobe.outStore && busBank == BANK_W'(i)) begin
        bankLen[i]   <= lenCapped;
        bankShort[i] <= newShort;
        bankOvf[i]   <= newOvf;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount  <= '0;
      shortPkt   <= 1'b0;
      overflow   <= 1'b0;
      txComplete <= 1'b0;
    end else if (epReset) begin
      byteCount  <= '0;
      shortPkt   <= 1'b0;
      overflow   <= 1'b0;
      txComplete <= 1'b0;
    end else begin
      if (strobe.inSent) txComplete <= 1'b1;
      if (strobe.outLoadNow || strobe.reloadNew) begin
        byteCount <= lenCapped;
        shortPkt  <= newShort;
        overflow  <= newOvf;
      end else if (strobe.reloadOld) begin
        byteCount <= bankLen[nextBank];
        shortPkt  <= bankShort[nextBank];
        overflow  <= bankOvf[nextBank];
      end else if (strobe.outClr || strobe.inFill) begin
        byteCount <= '0;
        shortPkt  <= 1'b0;
        overflow  <= 1'b0;
      end else if (strobe.byteInc && byteCount != CNT_MAX) begin
        byteCount <= byteCount + 1'b1;
      end else if (strobe.byteDec && byteCount != '0) begin
        byteCount <= byteCount - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ep_bank_tracker.sv
module ep_bank_tracker
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int LEN_W     = 11,
  parameter int BANK_W    = $clog2(NUM_BANKS + 1),
  parameter int STATUS_W  = LEN_W + 2 * BANK_W + 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                epReset,
  input  logic                cfgDirIn,
  input  logic [BANK_W-1:0]   cfgBanks,
  input  logic [LEN_W-1:0]    cfgSize,
  input  logic                fwWrite,
  input  logic                fwRead,
  input  logic                fwSetTxRdy,
  input  logic                fwClrRxRdy,
  input  logic                fwKill,
  input  logic                busOutStored,
  input  logic [LEN_W-1:0]    busOutLen,
  input  logic                busInAck,
  input  logic                busInToken,
  output logic [STATUS_W-1:0] statusWord,
  output logic                outNak
);

  epStrobe_t         strobe;
  logic [BANK_W-1:0] effBanks;
  logic [BANK_W-1:0] busyCnt;
  logic [BANK_W-1:0] curBank;
  logic [BANK_W-1:0] busBank;
  logic [BANK_W-1:0] nextBank;
  logic [LEN_W-1:0]  byteCount;
  logic              shortPkt;
  logic              overflow;
  logic              txComplete;
  logic              txRdy;
  logic              rxRdy;

  always_comb begin
    if (cfgBanks == '0)                    effBanks = BANK_W'(1);
    else if (cfgBanks > BANK_W'(NUM_BANKS)) effBanks = BANK_W'(NUM_BANKS);
    else                                   effBanks = cfgBanks;
    txRdy = cfgDirIn && (busyCnt == effBanks);
    rxRdy = !cfgDirIn && (busyCnt != '0);
    statusWord = {overflow, shortPkt, txComplete, rxRdy, txRdy, curBank, busyCnt, byteCount};
  end

  ep_bank_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .clk, .rstN, .epReset, .cfgDirIn, .effBanks,
    .fwWrite, .fwRead, .fwSetTxRdy, .fwClrRxRdy, .fwKill,
    .busOutStored, .busInAck, .busInToken,
    .strobe, .busyCnt, .curBank, .busBank, .nextBank, .outNak
  );

  ep_bank_data #(.NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W), .BANK_W(BANK_W)) u_data (
    .clk, .rstN, .epReset, .strobe, .cfgSize, .busOutLen,
    .busBank, .nextBank, .byteCount, .shortPkt, .overflow, .txComplete
  );

endmodule

// File: rtl/ep_bank_checker.sv
module ep_bank_checker #(
  parameter int NUM_BANKS = 3,
  parameter int LEN_W     = 11,
  parameter int BANK_W    = 2,
  parameter int STATUS_W  = 20
) (
  input logic                clk,
  input logic                rstN,
  input logic                epReset,
  input logic                cfgDirIn,
  input logic [BANK_W-1:0]   cfgBanks,
  input logic                fwSetTxRdy,
  input logic                fwKill,
  input logic                fwClrRxRdy,
  input logic                busInAck,
  input logic [STATUS_W-1:0] statusWord,
  input logic                outNak
);

  logic [BANK_W-1:0] lim;
  logic [BANK_W-1:0] busy;
  logic [BANK_W-1:0] cur;
  logic txRdy, rxRdy, txComplete;

  always_comb begin
    lim = (cfgBanks == '0) ? BANK_W'(1) :
          (cfgBanks > BANK_W'(NUM_BANKS)) ? BANK_W'(NUM_BANKS) : cfgBanks;
    busy       = statusWord[LEN_W +: BANK_W];
    cur        = statusWord[LEN_W + BANK_W +: BANK_W];
    txRdy      = statusWord[LEN_W + 2*BANK_W];
    rxRdy      = statusWord[LEN_W + 2*BANK_W + 1];
    txComplete = statusWord[LEN_W + 2*BANK_W + 2];
  end

  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busy <= lim); // R2
  AST_CUR_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    cur < lim); // R3
  AST_RDY_MUTEX: assert property (@(posedge clk) disable iff (!rstN)
    !(txRdy && rxRdy)); // R5
  AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDirIn && busInAck && !fwKill && !fwSetTxRdy && !epReset && busy != '0)
    |=> (txComplete && busy == $past(busy) - 1'b1)); // R6
  AST_TXC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txComplete && !epReset) |=> txComplete); // R6
  AST_NAK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    outNak |-> (!cfgDirIn && busy == lim)); // R11
  AST_NAK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outNak && !fwClrRxRdy && !epReset) |=> $stable(busy)); // R11
  AST_EP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    epReset |=> (statusWord == '0)); // R13

endmodule

bind ep_bank_tracker ep_bank_checker #(
  .NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W), .BANK_W(BANK_W), .STATUS_W(STATUS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .epReset(epReset), .cfgDirIn(cfgDirIn),
  .cfgBanks(cfgBanks), .fwSetTxRdy(fwSetTxRdy), .fwKill(fwKill),
  .fwClrRxRdy(fwClrRxRdy), .busInAck(busInAck),
  .statusWord(statusWord), .outNak(outNak)
);

// File: tb/sim_ep_bank_tracker.sv
module sim_ep_bank_tracker;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic epReset = 1'b0, cfgDirIn = 1'b1;
  logic [1:0] cfgBanks = 2'd1;
  logic [10:0] cfgSize = 11'd8;
  logic fwWrite = 0, fwRead = 0, fwSetTxRdy = 0, fwClrRxRdy = 0, fwKill = 0;
  logic busOutStored = 0, busInAck = 0, busInToken = 0;
  logic [10:0] busOutLen = '0;
  logic [19:0] statusWord;
  logic outNak;

  always #2 clk = ~clk;

  ep_bank_tracker u0 (.*);

  int nTests = 0, nFail = 0;
  int nb, sz; bit din;
  int mBusy, mCur, mBus, mCnt, mTxc, mSh, mOv;
  int mLen[3]; int mS[3]; int mO[3];

  function automatic int inc(int b); return (b + 1 >= nb) ? 0 : b + 1; endfunction
  function automatic int dec(int b); return (b == 0) ? nb - 1 : b - 1; endfunction

  function automatic logic [19:0] expSt();
    logic [19:0] e;
    e[10:0]  = 11'(mCnt);
    e[12:11] = 2'(mBusy);
    e[14:13] = 2'(mCur);
    e[15]    = din && (mBusy == nb);
    e[16]    = !din && (mBusy > 0);
    e[17]    = 1'(mTxc);
    e[18]    = 1'(mSh);
    e[19]    = 1'(mOv);
    return e;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h (banks=%0d size=%0d in=%0d)", tag, got, exp, nb, sz, din);
    end
  endtask

  task automatic chkSt(string tag); check(tag, 32'(statusWord), 32'(expSt())); endtask

  task automatic idle();
    {fwWrite, fwRead, fwSetTxRdy, fwClrRxRdy, fwKill, busOutStored, busInAck, busInToken, epReset} = '0;
  endtask

  task automatic zeroModel();
    {mBusy, mCur, mBus, mCnt, mTxc, mSh, mOv} = '{default: 0};
  endtask

  task automatic doEpReset();
    @(negedge clk); epReset = 1'b1;
    @(negedge clk); idle(); zeroModel();
    chkSt("R13 endpoint reset");
  endtask

  task automatic doWrite(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fwWrite = 1'b1;
      @(negedge clk); idle();
      if (din && mCnt < 2047) mCnt++;
    end
    chkSt(tag);
  endtask

  task automatic doSetTx(string tag);
    @(negedge clk); fwSetTxRdy = 1'b1;
    @(negedge clk); idle();
    if (din && mBusy < nb) begin mBusy++; mCur = inc(mCur); mCnt = 0; end
    chkSt(tag);
  endtask

  task automatic doAck(string tag);
    @(negedge clk); busInAck = 1'b1;
    @(negedge clk); idle();
    if (din && mBusy > 0) begin mBusy--; mBus = inc(mBus); mTxc = 1; end
    chkSt(tag);
  endtask

  task automatic doKill(bit tok, string tag);
    int sent, killed;
    @(negedge clk); fwKill = 1'b1; busInToken = tok;
    @(negedge clk); idle();
    if (din) begin
      sent = (tok && mBusy > 0) ? 1 : 0;
      killed = (mBusy >= (sent ? 2 : 1)) ? 1 : 0;
      if (sent) begin mBus = inc(mBus); mTxc = 1; end
      if (killed) mCur = dec(mCur);
      mBusy -= sent + killed;
    end
    chkSt(tag);
  endtask

  task automatic storeModel(int len, int b);
    mLen[b] = (len > sz) ? sz : len;
    mS[b] = (len < sz) ? 1 : 0;
    mO[b] = (len > sz) ? 1 : 0;
  endtask

  task automatic doStore(int len, string tag);
    @(negedge clk); busOutStored = 1'b1; busOutLen = 11'(len);
    #1 check("R11 nak flag", 32'(outNak), 32'(!din && mBusy == nb));
    @(negedge clk); idle();
    if (!din && mBusy < nb) begin
      storeModel(len, mBus);
      if (mBusy == 0) begin mCnt = mLen[mBus]; mSh = mS[mBus]; mOv = mO[mBus]; end
      mBus = inc(mBus); mBusy++;
    end
    chkSt(tag);
  endtask

  task automatic doRead(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fwRead = 1'b1;
      @(negedge clk); idle();
      if (!din && mCnt > 0) mCnt--;
    end
    chkSt(tag);
  endtask

  task automatic doClr(bit withStore, int len, string tag);
    int b0; bit ok; bit filled;
    @(negedge clk); fwClrRxRdy = 1'b1; busOutStored = withStore; busOutLen = 11'(len);
    @(negedge clk); idle();
    if (!din) begin
      b0 = mBusy;
      ok = withStore && (b0 < nb);
      if (ok) begin storeModel(len, mBus); mBus = inc(mBus); end
      if (b0 > 0) begin
        mCur = inc(mCur);
        filled = (b0 > 1) || (b0 == 1 && ok);
        mCnt = filled ? mLen[mCur] : 0;
        mSh  = filled ? mS[mCur] : 0;
        mOv  = filled ? mO[mCur] : 0;
      end else if (ok) begin
        mCnt = mLen[mCur]; mSh = mS[mCur]; mOv = mO[mCur];
      end
      mBusy = b0 + (ok ? 1 : 0) - (b0 > 0 ? 1 : 0);
    end
    chkSt(tag);
  endtask

  task automatic runIn();
    for (int k = 0; k <= nb; k++) begin
      doWrite(k + 2, "R4 write count");
      doSetTx("R2 R3 fill");
    end
    doWrite(3, "R4 write while full");
    doStore(5, "R12 out store in IN mode");
    doClr(1'b0, 0, "R12 clear rx in IN mode");
    doRead(1, "R12 read in IN mode");
    doKill(1'b0, "R7 kill no token");
    doAck("R6 ack");
    doSetTx("R3 refill");
    doSetTx("R2 refill");
    doKill(1'b1, "R7 kill with token");
    doKill(1'b1, "R7 kill with token again");
    doKill(1'b0, "R7 kill empty");
    doAck("R6 ack empty");
    doSetTx("R5 one bank");
    doKill(1'b1, "R7 kill refused");
  endtask

  task automatic runOut();
    doStore(sz - 3, "R8 short store");
    doStore(sz, "R8 full size store");
    doStore(sz + 5, "R8 overflow store");
    doStore(2, "R11 store when full");
    doWrite(2, "R12 write in OUT mode");
    doSetTx("R12 set tx in OUT mode");
    doAck("R12 ack in OUT mode");
    doKill(1'b1, "R12 kill in OUT mode");
    doRead(2, "R10 read");
    doClr(1'b0, 0, "R9 clear reload");
    doRead(sz + 2, "R10 read to zero");
    doClr(1'b0, 0, "R9 clear reload 2");
    doClr(1'b0, 0, "R9 clear reload 3");
    doClr(1'b1, sz - 1, "R9 clear with store");
    doClr(1'b1, sz + 1, "R9 clear with store 2");
    doClr(1'b0, 0, "R9 clear to empty");
    doClr(1'b0, 0, "R9 clear on empty");
  endtask

  initial begin
    #100000;
    nFail++; nTests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    nb = 1; sz = 8; din = 1'b1; zeroModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkSt("R1 bus reset state");
    for (int d = 1; d >= 0; d--) begin
      for (int b = 1; b <= 3; b++) begin
        for (int s = 0; s < 2; s++) begin
          doEpReset();
          nb = b; sz = (s == 0) ? 8 : 16; din = d[0];
          cfgBanks = 2'(b); cfgSize = 11'(sz); cfgDirIn = din;
          @(negedge clk);
          chkSt("R1 configured idle");
          if (din) runIn(); else runOut();
        end
      end
    end
    din = 1'b1; nb = 1; sz = 8;
    doEpReset();
    cfgBanks = 2'd0; cfgDirIn = 1'b1; cfgSize = 11'd8;
    @(negedge clk);
    doSetTx("R1 zero banks acts as one");
    doSetTx("R2 zero banks full");
    for (int i = 0; i < 2050; i++) begin
      @(negedge clk); fwWrite = 1'b1;
    end
    @(negedge clk); idle(); mCnt = 2047;
    chkSt("R4 saturation");
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; zeroModel();
    chkSt("R1 bus reset mid run");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule